// File: doc/BRIEF.md
# Debug Command Mode Controller

This block sits between a serial debug front end and a small 8-bit processor core. The front end hands it one decoded command at a time: an opcode, an address and a data word. The controller checks the command against the core's present mode (user run, halted for debug, wait or stop) and against a debug enable bit. It then carries the command out, drops it silently, or refuses it. Each accepted command is closed by a one-cycle `done` strobe with a result word and a refusal flag. Refused commands never stall the front end.

The controller owns the debug status/control byte, which is not visible to the core. It tracks the core's mode and drives register and memory strobes toward the core. It sequences the commands that do more than one thing: register reads and writes, single-instruction stepping, resuming the user program, and memory accesses that walk forward through the core's H:X register.

Top module: `dbg_cmd_ctrl`

## Requirements
- R1: After reset the mode is user run (mode code 0; codes are 0 user, 1 halted, 2 wait, 3 stop), the enable bit and the error flag are 0, `done` is low, `cmd_ready` is high and `cpu_run` is high.
- R2: Register commands use opcode 8+2k to read and 9+2k to write register k, where k is 0 for A, 1 for H:X, 2 for SP, 3 for PC and 4 for CCR, and `reg_sel` carries k. They run only in the halted mode. In any other mode they are refused and `reg_re`/`reg_we` stay low.
- R3: The commands control write (1), status read (2), byte read (3), byte write (4) and last-byte read (5) never assert `reg_re` or `reg_we`.
- R4: Break-in (opcode 0) with the enable bit set moves the core to the halted mode on the next cycle, from user, wait or stop. With the enable bit clear it completes without refusal, leaves the mode unchanged and does not set the error flag.
- R5: In wait or stop, every opcode except break-in is refused and no memory access is made.
- R6: Control write is the only command that changes the enable bit. It loads the bit from `cmd_data[7]` and clears the error flag. Status read returns, in `rdata[7:0]`, the byte {enable, halted, error, mode[1:0], 3'b000}.
- R7: Read-next (6) and write-next (7) run only in the halted mode. Each adds 1 to H:X, writes the new value back, and then accesses memory at the new address. Write-next stores `cmd_data[7:0]`. `rdata[15:8]` holds the status byte from before the command, and `rdata[7:0]` holds the byte read, or 0 for a write. `done` comes two cycles after acceptance.
- R8: Step (18) puts the core in user mode until `cpu_step_done` is seen. The mode then returns to halted, and `done` is raised on the following cycle.
- R9: Resume (19) and tagged resume (20) put the core in user mode, and `cpu_run` is high exactly while the mode is user.
- R10: Byte read and byte write at `cmd_addr` run in both user and halted modes. Last-byte read returns the most recent byte fetched by a byte read or a read-next.
- R11: A refused command, including an undefined opcode, raises `refused` together with `done` and sets the sticky error flag.
- R12: Single-cycle commands raise `done` for exactly one cycle, one cycle after acceptance, with `rdata` 0 when there is no result. `cmd_ready` is low while a multi-cycle command is in flight.
- R13: In user mode with no command in flight, `cpu_stop` enters stop and otherwise `cpu_wait` enters wait. Stop wins when both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command presented |
| cmd_ready | output | 1 | Controller can accept a command |
| cmd_op | input | 5 | Command opcode |
| cmd_addr | input | 16 | Address for byte read and write |
| cmd_data | input | 16 | Write data or control byte |
| done | output | 1 | One-cycle completion strobe |
| refused | output | 1 | Command was refused (valid with done) |
| rdata | output | 16 | Result word (valid with done) |
| mode | output | 2 | Current core mode |
| cpu_run | output | 1 | Core runs the user program |
| cpu_wait | input | 1 | Core has executed a wait |
| cpu_stop | input | 1 | Core has executed a stop |
| cpu_step_done | input | 1 | Core retired the stepped instruction |
| reg_re | output | 1 | Core register read strobe |
| reg_we | output | 1 | Core register write strobe |
| reg_sel | output | 3 | Core register selector |
| reg_wdata | output | 16 | Core register write data |
| reg_rdata | input | 16 | Core register read data |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |

## Verification
The same opcodes are issued in each of the four modes, and with the enable bit both set and clear. This separates running a command from refusing it and from dropping it silently, and shows whether break-in is gated by the enable bit rather than by the mode. Read-next and write-next are issued back to back from a known H:X value. This shows whether the pointer is incremented before or after the access and whether the result carries the earlier status byte. Wait and stop are raised alone and together to fix their priority, and a step with a delayed retire shows that the controller waits for the core rather than a fixed delay.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    typedef enum logic [1:0] {
        MODE_USER = 2'd0,
        MODE_HALT = 2'd1,
        MODE_WAIT = 2'd2,
        MODE_STOP = 2'd3
    } mode_e;

    typedef enum logic [4:0] {
        OP_BREAK    = 5'd0,
        OP_CTRL_WR  = 5'd1,
        OP_STAT_RD  = 5'd2,
        OP_BYTE_RD  = 5'd3,
        OP_BYTE_WR  = 5'd4,
        OP_LAST_RD  = 5'd5,
        OP_NEXT_RD  = 5'd6,
        OP_NEXT_WR  = 5'd7,
        OP_RD_A     = 5'd8,
        OP_WR_A     = 5'd9,
        OP_RD_HX    = 5'd10,
        OP_WR_HX    = 5'd11,
        OP_RD_SP    = 5'd12,
        OP_WR_SP    = 5'd13,
        OP_RD_PC    = 5'd14,
        OP_WR_PC    = 5'd15,
        OP_RD_CCR   = 5'd16,
        OP_WR_CCR   = 5'd17,
        OP_STEP     = 5'd18,
        OP_RESUME   = 5'd19,
        OP_RESUME_T = 5'd20
    } op_e;

    typedef enum logic [1:0] {
        ACT_RUN    = 2'd0,
        ACT_REFUSE = 2'd1,
        ACT_IGNORE = 2'd2
    } act_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_NEXT = 2'd1,
        ST_STEP = 2'd2
    } fsm_e;

    localparam logic [2:0] SEL_HX = 3'd1;

    function automatic logic [7:0] stat_byte(logic en, logic err, mode_e m);
        return {en, (m == MODE_HALT), err, m, 3'b000};
    endfunction

endpackage

// File: rtl/dbg_cmd_gate.sv
module dbg_cmd_gate
    import dbg_pkg::*;
(
    input  logic [4:0] op,
    input  mode_e      cur_mode,
    input  logic       en,
    output act_e       act
);
    logic low_power;
    logic halted;

    always_comb begin
        low_power = (cur_mode == MODE_WAIT) || (cur_mode == MODE_STOP);
        halted    = (cur_mode == MODE_HALT);
        act       = ACT_REFUSE;
        if (op == OP_BREAK) begin
            act = en ? ACT_RUN : ACT_IGNORE;
        end else if (!low_power) begin
            unique case (op)
                OP_CTRL_WR, OP_STAT_RD, OP_BYTE_RD,
                OP_BYTE_WR, OP_LAST_RD:
                    act = ACT_RUN;
                OP_NEXT_RD, OP_NEXT_WR,
                OP_RD_A,  OP_WR_A,  OP_RD_HX, OP_WR_HX,
                OP_RD_SP, OP_WR_SP, OP_RD_PC, OP_WR_PC,
                OP_RD_CCR, OP_WR_CCR,
                OP_STEP, OP_RESUME, OP_RESUME_T:
                    act = halted ? ACT_RUN : ACT_REFUSE;
                default:
                    act = ACT_REFUSE;
            endcase
        end
    end
endmodule

// File: rtl/dbg_status_reg.sv
module dbg_status_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic ctrl_en,
    input  logic set_err,
    output logic en,
    output logic err
);
    typedef struct packed {
        logic en;
        logic err;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctrl_wr) begin
            st_d.en  = ctrl_en;
            st_d.err = 1'b0;
        end
        if (set_err) begin
            st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en  = st_q.en;
    assign err = st_q.err;
endmodule

// File: rtl/dbg_cmd_ctrl.sv
module dbg_cmd_ctrl
    import dbg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [4:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [ADDR_W-1:0] cmd_data,
    output logic              done,
    output logic              refused,
    output logic [2*DATA_W-1:0] rdata,
    output logic [1:0]        mode,
    output logic              cpu_run,
    input  logic              cpu_wait,
    input  logic              cpu_stop,
    input  logic              cpu_step_done,
    output logic              reg_re,
    output logic              reg_we,
    output logic [2:0]        reg_sel,
    output logic [ADDR_W-1:0] reg_wdata,
    input  logic [ADDR_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int RD_W = 2 * DATA_W;

    typedef struct packed {
        mode_e             mode;
        fsm_e              fsm;
        logic              done;
        logic              refused;
        logic [RD_W-1:0]   rdata;
        logic [ADDR_W-1:0] ptr;
        logic [DATA_W-1:0] last;
        logic              nwr;
        logic [DATA_W-1:0] wbyte;
    } ctl_t;

    ctl_t st_d, st_q;

    logic       accept;
    act_e       act;
    logic       stat_en;
    logic       stat_err;
    logic       ctrl_wr;
    logic       set_err;
    logic [3:0] roff;
    logic [7:0] status;

    dbg_cmd_gate u_gate (
        .op       (cmd_op),
        .cur_mode (st_q.mode),
        .en       (stat_en),
        .act      (act)
    );

    dbg_status_reg u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .ctrl_en (cmd_data[7]),
        .set_err (set_err),
        .en      (stat_en),
        .err     (stat_err)
    );

    assign accept  = cmd_valid && (st_q.fsm == ST_IDLE);
    assign ctrl_wr = accept && (act == ACT_RUN) && (cmd_op == OP_CTRL_WR);
    assign set_err = accept && (act == ACT_REFUSE);
    assign roff    = cmd_op[3:0] - 4'd8;
    assign status  = stat_byte(stat_en, stat_err, st_q.mode);

    always_comb begin
        st_d         = st_q;
        st_d.done    = 1'b0;
        st_d.refused = 1'b0;
        reg_re       = 1'b0;
        reg_we       = 1'b0;
        reg_sel      = '0;
        reg_wdata    = cmd_data;
        mem_req      = 1'b0;
        mem_we       = 1'b0;
        mem_addr     = cmd_addr;
        mem_wdata    = cmd_data[DATA_W-1:0];

        unique case (st_q.fsm)
            ST_IDLE: begin
                if (accept) begin
                    st_d.done    = 1'b1;
                    st_d.refused = (act == ACT_REFUSE);
                    st_d.rdata   = '0;
                    if (act == ACT_RUN) begin
                        unique case (cmd_op)
                            OP_BREAK:   st_d.mode = MODE_HALT;
                            OP_CTRL_WR: ;
                            OP_STAT_RD: st_d.rdata = RD_W'(status);
                            OP_BYTE_RD: begin
                                mem_req    = 1'b1;
                                st_d.rdata = RD_W'(mem_rdata);
                                st_d.last  = mem_rdata;
                            end
                            OP_BYTE_WR: begin
                                mem_req = 1'b1;
                                mem_we  = 1'b1;
                            end
                            OP_LAST_RD: st_d.rdata = RD_W'(st_q.last);
                            OP_NEXT_RD, OP_NEXT_WR: begin
                                reg_re     = 1'b1;
                                reg_sel    = SEL_HX;
                                st_d.ptr   = reg_rdata + 1'b1;
                                st_d.nwr   = (cmd_op == OP_NEXT_WR);
                                st_d.wbyte = cmd_data[DATA_W-1:0];
                                st_d.rdata = {DATA_W'(status), DATA_W'(0)};
                                st_d.done  = 1'b0;
                                st_d.fsm   = ST_NEXT;
                            end
                            OP_STEP: begin
                                st_d.mode = MODE_USER;
                                st_d.done = 1'b0;
                                st_d.fsm  = ST_STEP;
                            end
                            OP_RESUME, OP_RESUME_T: st_d.mode = MODE_USER;
                            default: begin
                                reg_sel    = roff[3:1];
                                reg_we     = roff[0];
                                reg_re     = !roff[0];
                                st_d.rdata = roff[0] ? '0 : RD_W'(reg_rdata);
                            end
                        endcase
                    end
                end else if (st_q.mode == MODE_USER) begin
                    if (cpu_stop) begin
                        st_d.mode = MODE_STOP;
                    end else if (cpu_wait) begin
                        st_d.mode = MODE_WAIT;
                    end
                end
            end
            ST_NEXT: begin
                reg_we    = 1'b1;
                reg_sel   = SEL_HX;
                reg_wdata = st_q.ptr;
                mem_req   = 1'b1;
                mem_we    = st_q.nwr;
                mem_addr  = st_q.ptr;
                mem_wdata = st_q.wbyte;
                if (!st_q.nwr) begin
                    st_d.rdata = {st_q.rdata[RD_W-1 -: DATA_W], mem_rdata};
                    st_d.last  = mem_rdata;
                end
                st_d.done = 1'b1;
                st_d.fsm  = ST_IDLE;
            end
            ST_STEP: begin
                if (cpu_step_done) begin
                    st_d.mode = MODE_HALT;
                    st_d.done = 1'b1;
                    st_d.fsm  = ST_IDLE;
                end
            end
            default: st_d.fsm = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_ready = (st_q.fsm == ST_IDLE);
    assign done      = st_q.done;
    assign refused   = st_q.refused;
    assign rdata     = st_q.rdata;
    assign mode      = st_q.mode;
    assign cpu_run   = (st_q.mode == MODE_USER);
endmodule

// File: rtl/dbg_cmd_chk.sv
module dbg_cmd_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic [4:0] cmd_op,
    input logic       done,
    input logic       refused,
    input logic [1:0] mode,
    input logic       reg_re,
    input logic       reg_we,
    input logic       mem_req,
    input logic       en,
    input logic       err
);
    logic take;
    assign take = cmd_valid && cmd_ready;

    // R2
    reg_only_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_re || reg_we) |-> (mode == 2'd1));

    // R3
    nonintrusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (cmd_op >= 5'd1) && (cmd_op <= 5'd5)) |-> (!reg_re && !reg_we));

    // R5
    lowpower_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1]) |-> !mem_req);

    // R6
    en_only_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(en) |-> $past(take && (cmd_op == 5'd1)));

    // R4
    break_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (cmd_op == 5'd0) && en) |=> (mode == 2'd1));

    // R4
    break_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (cmd_op == 5'd0) && !en) |=> ($stable(mode) && !refused));

    // R11
    refuse_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && refused) |-> err);
endmodule

bind dbg_cmd_ctrl dbg_cmd_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .done      (done),
    .refused   (refused),
    .mode      (mode),
    .reg_re    (reg_re),
    .reg_we    (reg_we),
    .mem_req   (mem_req),
    .en        (stat_en),
    .err       (stat_err)
);

// File: tb/tb_dbg_cmd_ctrl.sv
module tb_dbg_cmd_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [4:0]  cmd_op = '0;
    logic [15:0] cmd_addr = '0;
    logic [15:0] cmd_data = '0;
    logic        done, refused;
    logic [15:0] rdata;
    logic [1:0]  mode;
    logic        cpu_run;
    logic        cpu_wait = 1'b0, cpu_stop = 1'b0, cpu_step_done = 1'b0;
    logic        reg_re, reg_we;
    logic [2:0]  reg_sel;
    logic [15:0] reg_wdata, reg_rdata;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;

    always #4 clk = ~clk;

    dbg_cmd_ctrl dut (.*);

    // Core side seen by the controller
    logic [15:0] a_reg [5];
    logic [7:0]  a_mem [256];
    always_comb reg_rdata = (reg_sel < 3'd5) ? a_reg[reg_sel] : 16'h0;
    always_comb mem_rdata = a_mem[mem_addr[7:0]];
    always @(posedge clk) begin
        if (reg_we && reg_sel < 3'd5) a_reg[reg_sel] <= reg_wdata;
        if (mem_req && mem_we) a_mem[mem_addr[7:0]] <= mem_wdata;
    end

    // Reference model
    logic [15:0] m_reg [5];
    logic [7:0]  m_mem [256];
    int   exp_mode = 0;
    bit   exp_en = 0, exp_err = 0;
    logic [7:0] exp_last = 0;
    bit   mon_on = 0;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #2;
        if (mon_on) begin
            check(mode == exp_mode[1:0], "R13 mode tracks model", mode, exp_mode);
            check(cpu_run == (exp_mode == 0), "R9 cpu_run follows user mode", cpu_run, exp_mode == 0);
            check(!((reg_re || reg_we) && exp_mode != 1), "R2 register strobe outside halted", {reg_re, reg_we}, 0);
            check(!(mem_req && exp_mode >= 2), "R5 memory access in low power", mem_req, 0);
        end
    end

    function automatic logic [7:0] m_status();
        return {exp_en, exp_mode == 1, exp_err, exp_mode[1:0], 3'b000};
    endfunction

    int  n_mode;
    bit  n_en, n_err, e_ref;
    logic [15:0] e_rd;
    int  e_lat;

    task automatic predict(input logic [4:0] op, input logic [15:0] a, input logic [15:0] d);
        bit halted = (exp_mode == 1);
        logic [7:0] s = m_status();
        n_mode = exp_mode; n_en = exp_en; n_err = exp_err;
        e_ref = 0; e_rd = 0; e_lat = 1;
        if (op == 0) begin
            if (exp_en) n_mode = 1;
        end else if (exp_mode >= 2) begin
            e_ref = 1;
        end else begin
            case (op)
                1: begin n_en = d[7]; n_err = 0; end
                2: e_rd = {8'h00, s};
                3: begin e_rd = {8'h00, m_mem[a[7:0]]}; exp_last = m_mem[a[7:0]]; end
                4: m_mem[a[7:0]] = d[7:0];
                5: e_rd = {8'h00, exp_last};
                6, 7: begin
                    if (!halted) e_ref = 1;
                    else begin
                        m_reg[1] = m_reg[1] + 16'd1;
                        e_lat = 2;
                        if (op == 7) begin
                            m_mem[m_reg[1][7:0]] = d[7:0];
                            e_rd = {s, 8'h00};
                        end else begin
                            exp_last = m_mem[m_reg[1][7:0]];
                            e_rd = {s, exp_last};
                        end
                    end
                end
                8, 9, 10, 11, 12, 13, 14, 15, 16, 17: begin
                    if (!halted) e_ref = 1;
                    else if (op[0]) m_reg[(op - 9) / 2] = d;
                    else e_rd = m_reg[(op - 8) / 2];
                end
                18, 19, 20: begin
                    if (!halted) e_ref = 1;
                    else n_mode = 0;
                end
                default: e_ref = 1;
            endcase
        end
        if (e_ref) n_err = 1;
    endtask

    task automatic cmp_core(input string tag);
        bit ok = 1;
        for (int i = 0; i < 5; i++) if (a_reg[i] !== m_reg[i]) ok = 0;
        for (int i = 0; i < 256; i++) if (a_mem[i] !== m_mem[i]) ok = 0;
        check(ok, {tag, " core state"}, a_reg[1], m_reg[1]);
    endtask

    task automatic drive(input logic [4:0] op, input logic [15:0] a, input logic [15:0] d, input string tag);
        predict(op, a, d);
        @(negedge clk);
        check(cmd_ready, {tag, " ready before issue"}, cmd_ready, 1);
        cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_data = d;
        @(posedge clk);
        #1;
        cmd_valid = 0;
        exp_mode = n_mode; exp_en = n_en; exp_err = n_err;
    endtask

    task automatic cmd(input logic [4:0] op, input logic [15:0] a, input logic [15:0] d, input string tag);
        int lat = 0;
        drive(op, a, d, tag);
        do begin
            @(negedge clk);
            lat++;
            if (!done) check(lat == 1 ? 1'b1 : !cmd_ready || lat > e_lat, {tag, " R12 busy"}, cmd_ready, 0);
        end while (!done && lat < 20);
        check(done && lat == e_lat, {tag, " R12 done latency"}, lat, e_lat);
        check(refused == e_ref, {tag, " refused flag"}, refused, e_ref);
        check(rdata == e_rd, {tag, " result"}, rdata, e_rd);
        @(negedge clk);
        check(!done && cmd_ready, {tag, " R12 single pulse"}, done, 0);
        cmp_core(tag);
    endtask

    task automatic pulse_lp(input bit w, input bit s);
        @(negedge clk);
        cpu_wait = w; cpu_stop = s;
        @(posedge clk);
        #1;
        cpu_wait = 0; cpu_stop = 0;
        if (exp_mode == 0) exp_mode = s ? 3 : (w ? 2 : 0);
    endtask

    initial begin
        #(8 * 150000);
        check(0, "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            a_mem[i] = 8'(i) ^ 8'h3C;
            m_mem[i] = 8'(i) ^ 8'h3C;
        end
        for (int i = 0; i < 5; i++) begin
            a_reg[i] = 16'h0;
            m_reg[i] = 16'h0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #2;
        check(mode == 2'd0 && !done && cmd_ready && cpu_run, "R1 reset state",
              {mode, done, cmd_ready, cpu_run}, 4'b0011);
        mon_on = 1;
        cmd(5'd2, 0, 0, "R1 status after reset");

        cmd(5'd8, 0, 0, "R2 read A refused in user");
        cmd(5'd11, 0, 16'h1234, "R2 write HX refused in user");
        cmd(5'd2, 0, 0, "R11 error flag sticky");
        cmd(5'd0, 0, 0, "R4 break-in ignored when disabled");
        cmd(5'd1, 0, 16'h0080, "R6 control write sets enable");
        cmd(5'd2, 0, 0, "R6 status after control write");
        cmd(5'd6, 0, 0, "R7 read-next refused in user");
        cmd(5'd4, 16'h0010, 16'h005A, "R10 byte write in user");
        cmd(5'd3, 16'h0010, 0, "R10 byte read in user");
        cmd(5'd5, 0, 0, "R10 last byte");
        cmd(5'd18, 0, 0, "R8 step refused in user");
        cmd(5'd1, 0, 16'h0080, "R6 clear error");
        cmd(5'd0, 0, 0, "R4 break-in from user");
        cmd(5'd2, 0, 0, "R6 status when halted");
        cmd(5'd11, 0, 16'h001F, "R2 write HX");
        cmd(5'd9, 0, 16'h00A7, "R2 write A");
        cmd(5'd13, 0, 16'h01F0, "R2 write SP");
        cmd(5'd15, 0, 16'hC000, "R2 write PC");
        cmd(5'd17, 0, 16'h0063, "R2 write CCR");
        cmd(5'd8, 0, 0, "R2 read A");
        cmd(5'd12, 0, 0, "R2 read SP");
        cmd(5'd14, 0, 0, "R2 read PC");
        cmd(5'd16, 0, 0, "R2 read CCR");
        cmd(5'd7, 0, 16'h0011, "R7 write-next");
        cmd(5'd6, 0, 0, "R7 read-next");
        cmd(5'd6, 0, 0, "R7 read-next again");
        cmd(5'd10, 0, 0, "R7 HX after walk");
        cmd(5'd5, 0, 0, "R10 last byte after read-next");
        cmd(5'd3, 16'h0040, 0, "R10 byte read halted");
        cmd(5'd2, 0, 0, "R3 status read halted");

        // step with delayed retire
        drive(5'd18, 0, 0, "R8 step");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(!done, "R8 no done before retire", done, 0);
        end
        cpu_step_done = 1;
        @(posedge clk);
        #1;
        cpu_step_done = 0;
        exp_mode = 1;
        @(negedge clk);
        check(done && !refused, "R8 done after retire", {done, refused}, 2'b10);

        cmd(5'd19, 0, 0, "R9 resume");
        cmd(5'd8, 0, 0, "R2 read A refused after resume");
        pulse_lp(1, 0);
        cmd(5'd3, 16'h0010, 0, "R5 byte read refused in wait");
        cmd(5'd1, 0, 16'h0000, "R5 control write refused in wait");
        cmd(5'd0, 0, 0, "R4 break-in from wait");
        cmd(5'd20, 0, 0, "R9 tagged resume");
        pulse_lp(1, 1);
        cmd(5'd2, 0, 0, "R5 status refused in stop");
        cmd(5'd0, 0, 0, "R4 break-in from stop");
        cmd(5'd19, 0, 0, "R9 resume again");
        cmd(5'd1, 0, 16'h0000, "R6 control write clears enable");
        cmd(5'd31, 0, 0, "R11 undefined opcode");
        pulse_lp(1, 0);
        cmd(5'd0, 0, 0, "R4 break-in ignored in wait when disabled");
        cmd(5'd4, 16'h0020, 16'h00EE, "R5 byte write refused in wait");
        repeat (2) @(negedge clk);
        summary();
    end
endmodule